// File: doc/BRIEF.md
# Accelerator Launch and Interrupt Register Block

This block is the software-facing control point of a frame-processing engine. A processor reaches it through an AXI4-Lite slave port with 32-bit data. Over that port it launches frames, switches the engine into free-running mode and reads progress flags. It also configures which engine events raise an interrupt, clears pending events and sets up a 64-bit pointer to the engine's work descriptor.

Towards the engine, the block issues a one-cycle start pulse and drives the descriptor pointer as a flat vector. It takes two one-cycle event pulses from the engine: one when a frame completes and one when the engine can accept the next frame. Event reporting has two levels. A per-source enable decides whether an event is latched as pending. A single master enable decides whether any pending event drives the level-sensitive interrupt line.

Top module: `acr_regfile`

## Requirements
- R1: Each write completes with one B response and each read with one R response, both OKAY (resp = 0). Only one write and one read are outstanding at a time. Byte address bits [1:0] are ignored.
- R2: After reset every stored field is 0. The control word reads 0x0000000C (idle and can-accept set), `irq_o` is 0 and `core_start_o` is 0.
- R3: A write to offset 0x00 with strobe bit 0 set and data bit 0 equal to 1 sets the launch flag (control bit 0). `core_start_o` is then 1 for exactly the cycle after the write handshake.
- R4: While auto-restart (control bit 7) is 0, a ready event clears the launch flag. While auto-restart is 1 and the launch flag is set, each ready event keeps the flag set and issues another start pulse in the following cycle.
- R5: Control bit 1 is set by a done event and cleared by a read of offset 0x00; a done event in the same cycle as that read wins. Bit 2 (idle) is 1 when a done event has arrived since the last launch. Bit 3 (can-accept) is the inverse of the launch flag.
- R6: Offset 0x08 holds the per-source enables: bit 0 for the done event and bit 1 for the ready event. An event sets its bit in the pending word at offset 0x0C only while its enable is 1.
- R7: Writing 1 to a bit of the pending word clears that bit; writing 0 leaves it unchanged. An event arriving in the same cycle as the clear keeps the bit set.
- R8: `irq_o` is 1 exactly when bit 0 of offset 0x04 is 1 and at least one pending bit is set.
- R9: Offsets 0x10 and 0x14 hold the low and high 32 bits of `desc_ptr_o`. They are read/write with per-byte strobes.
- R10: Reserved bits read as 0 and ignore writes. Offsets other than 0x00 to 0x14 read 0 with an OKAY response, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | ADDR_W | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| core_start_o | output | 1 | One-cycle launch pulse to the engine |
| core_done_i | input | 1 | Frame-complete event pulse |
| core_ready_i | input | 1 | Ready-for-next-frame event pulse |
| desc_ptr_o | output | PTR_W | Descriptor pointer |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench uses the default parameters: an 8-bit address and a 64-bit pointer split into two words. With an 8-bit address, 64 word slots are decodable. Random stimulus can therefore reach the 58 undefined slots as well as both pointer words with every strobe pattern. Because the pointer is exactly two words, the high/low split and the byte-lane merge are exercised on both halves. Directed cases cover the collisions that random stimulus rarely produces: a pending-bit clear in the same cycle as an event, and back-to-back auto-restart relaunches.

// File: rtl/acr_pkg.sv
package acr_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned NSRC   = 2;
  // word indices (byte offset / 4)
  localparam int unsigned IX_CTL = 0;
  localparam int unsigned IX_GIE = 1;
  localparam int unsigned IX_IEN = 2;
  localparam int unsigned IX_PND = 3;
  localparam int unsigned IX_DSC = 4;
  // control word bit positions
  localparam int unsigned CB_GO   = 0;
  localparam int unsigned CB_DONE = 1;
  localparam int unsigned CB_IDLE = 2;
  localparam int unsigned CB_RDY  = 3;
  localparam int unsigned CB_AUTO = 7;

  typedef struct packed {
    logic go;
    logic done;
    logic idle;
    logic auto_rs;
  } ctl_view_t;

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_v,
                                               input logic [DW-1:0] new_v,
                                               input logic [DW/8-1:0] strb);
    logic [DW-1:0] r;
    r = old_v;
    for (int b = 0; b < DW/8; b++)
      if (strb[b]) r[8*b +: 8] = new_v[8*b +: 8];
    return r;
  endfunction

  function automatic logic [DW-1:0] ctl_pack(input ctl_view_t v);
    logic [DW-1:0] w;
    w = '0;
    w[CB_GO]   = v.go;
    w[CB_DONE] = v.done;
    w[CB_IDLE] = v.idle;
    w[CB_RDY]  = ~v.go;
    w[CB_AUTO] = v.auto_rs;
    return w;
  endfunction
endpackage

// File: rtl/acr_axil_slave.sv
module acr_axil_slave #(
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [31:0]       wdata,
  input  logic [3:0]        wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic              bvalid,
  input  logic              bready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [31:0]       rdata,
  output logic              rvalid,
  input  logic              rready,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [31:0]       wr_data,
  output logic [3:0]        wr_strb,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [31:0]       rd_word
);
  logic bvalid_q, rvalid_q;
  logic [31:0] rdata_q;

  assign awready = wvalid & ~bvalid_q;
  assign wready  = awvalid & ~bvalid_q;
  assign wr_en   = awvalid & wvalid & ~bvalid_q;
  assign wr_idx  = awaddr[ADDR_W-1:2];
  assign wr_data = wdata;
  assign wr_strb = wstrb;

  assign arready = ~rvalid_q;
  assign rd_en   = arvalid & ~rvalid_q;
  assign rd_idx  = araddr[ADDR_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (wr_en) bvalid_q <= 1'b1;
      else if (bready) bvalid_q <= 1'b0;
      if (rd_en) begin
        rvalid_q <= 1'b1;
        rdata_q  <= rd_word;
      end else if (rready) begin
        rvalid_q <= 1'b0;
      end
    end
  end

  assign bvalid = bvalid_q;
  assign rvalid = rvalid_q;
  assign rdata  = rdata_q;
endmodule

// File: rtl/acr_launch_ctl.sv
module acr_launch_ctl
  import acr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic [31:0] wdata,
  input  logic        strb0,
  input  logic        ctl_rd,
  input  logic        ev_done,
  input  logic        ev_ready,
  output logic        launch,
  output logic        go_flag,
  output logic        start_pulse,
  output logic [31:0] ctl_word
);
  logic go_q, auto_q, busy_q, done_q, pulse_q;
  logic sw_go, relaunch;
  ctl_view_t view;

  assign sw_go    = ctl_wr & strb0 & wdata[CB_GO];
  assign relaunch = ev_ready & go_q & auto_q;
  assign launch   = sw_go | relaunch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q    <= 1'b0;
      auto_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= launch;
      if (sw_go) go_q <= 1'b1;
      else if (ev_ready && !auto_q) go_q <= 1'b0;
      if (ctl_wr && strb0) auto_q <= wdata[CB_AUTO];
      if (launch) busy_q <= 1'b1;
      else if (ev_done) busy_q <= 1'b0;
      if (ev_done) done_q <= 1'b1;
      else if (ctl_rd) done_q <= 1'b0;
    end
  end

  always_comb begin
    view.go      = go_q;
    view.done    = done_q;
    view.idle    = ~busy_q;
    view.auto_rs = auto_q;
    ctl_word     = ctl_pack(view);
  end

  assign go_flag     = go_q;
  assign start_pulse = pulse_q;
endmodule

// File: rtl/acr_irq_ctl.sv
module acr_irq_ctl #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gie_wr,
  input  logic            ien_wr,
  input  logic            pnd_wr,
  input  logic [31:0]     wdata,
  input  logic            strb0,
  input  logic [NSRC-1:0] ev,
  output logic [NSRC-1:0] pnd_set,
  output logic [NSRC-1:0] pnd_clr,
  output logic            gie_bit,
  output logic [NSRC-1:0] ien_bits,
  output logic [NSRC-1:0] pnd_bits,
  output logic            irq
);
  logic            gie_q;
  logic [NSRC-1:0] ien_q, pnd_q;

  assign pnd_set = ev & ien_q;
  assign pnd_clr = (pnd_wr && strb0) ? wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      ien_q <= '0;
      pnd_q <= '0;
    end else begin
      if (gie_wr && strb0) gie_q <= wdata[0];
      if (ien_wr && strb0) ien_q <= wdata[NSRC-1:0];
      pnd_q <= (pnd_q & ~pnd_clr) | pnd_set;
    end
  end

  assign gie_bit  = gie_q;
  assign ien_bits = ien_q;
  assign pnd_bits = pnd_q;
  assign irq      = gie_q & (|pnd_q);
endmodule

// File: rtl/acr_regfile.sv
module acr_regfile
  import acr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PTR_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              core_start_o,
  input  logic              core_done_i,
  input  logic              core_ready_i,
  output logic [PTR_W-1:0]  desc_ptr_o,
  output logic              irq_o
);
  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam int unsigned NWORDS = PTR_W / 32;

  logic             wr_en, rd_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [31:0]      wr_data, rd_word, ctl_word;
  logic [3:0]       wr_strb;
  logic             launch, go_flag, gie_bit;
  logic [NSRC-1:0]  pnd_set, pnd_clr, ien_bits, pnd_bits, ev_vec;
  logic             ctl_wr, gie_wr, ien_wr, pnd_wr, ctl_rd;
  logic [31:0]      dsc_q [NWORDS];

  acr_axil_slave #(.ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bvalid(s_bvalid), .bready(s_bready),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rvalid(s_rvalid), .rready(s_rready),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_word(rd_word)
  );

  assign s_bresp = 2'b00;
  assign s_rresp = 2'b00;

  assign ctl_wr = wr_en && (wr_idx == IDX_W'(IX_CTL));
  assign gie_wr = wr_en && (wr_idx == IDX_W'(IX_GIE));
  assign ien_wr = wr_en && (wr_idx == IDX_W'(IX_IEN));
  assign pnd_wr = wr_en && (wr_idx == IDX_W'(IX_PND));
  assign ctl_rd = rd_en && (rd_idx == IDX_W'(IX_CTL));
  assign ev_vec = {core_ready_i, core_done_i};

  acr_launch_ctl u_launch (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .wdata(wr_data), .strb0(wr_strb[0]), .ctl_rd(ctl_rd),
    .ev_done(core_done_i), .ev_ready(core_ready_i),
    .launch(launch), .go_flag(go_flag), .start_pulse(core_start_o),
    .ctl_word(ctl_word)
  );

  acr_irq_ctl #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .gie_wr(gie_wr), .ien_wr(ien_wr), .pnd_wr(pnd_wr),
    .wdata(wr_data), .strb0(wr_strb[0]), .ev(ev_vec),
    .pnd_set(pnd_set), .pnd_clr(pnd_clr),
    .gie_bit(gie_bit), .ien_bits(ien_bits), .pnd_bits(pnd_bits), .irq(irq_o)
  );

  for (genvar g = 0; g < NWORDS; g++) begin : g_dsc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dsc_q[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(IX_DSC + g)))
        dsc_q[g] <= lane_merge(dsc_q[g], wr_data, wr_strb);
    end
    assign desc_ptr_o[32*g +: 32] = dsc_q[g];
  end

  always_comb begin
    rd_word = '0;
    if (rd_idx == IDX_W'(IX_CTL)) rd_word = ctl_word;
    else if (rd_idx == IDX_W'(IX_GIE)) rd_word[0] = gie_bit;
    else if (rd_idx == IDX_W'(IX_IEN)) rd_word[NSRC-1:0] = ien_bits;
    else if (rd_idx == IDX_W'(IX_PND)) rd_word[NSRC-1:0] = pnd_bits;
    else begin
      for (int k = 0; k < NWORDS; k++)
        if (rd_idx == IDX_W'(IX_DSC + k)) rd_word = dsc_q[k];
    end
  end
endmodule

// File: rtl/acr_regfile_chk.sv
module acr_regfile_chk #(
  parameter int unsigned NSRC = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_o,
  input logic            core_start_o,
  input logic            go_flag,
  input logic            gie_wr,
  input logic [NSRC-1:0] pnd_bits,
  input logic [NSRC-1:0] pnd_set,
  input logic [NSRC-1:0] pnd_clr,
  input logic            bvalid,
  input logic            bready,
  input logic [1:0]      bresp,
  input logic            rvalid,
  input logic            rready,
  input logic [1:0]      rresp,
  input logic [31:0]     rdata
);
  // R1
  bresp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> bresp == 2'b00);
  // R1
  rresp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> rresp == 2'b00);
  // R1
  bvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid);
  // R1
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata));
  // R3
  start_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start_o |-> go_flag);
  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !gie_wr && (pnd_clr == '0) |=> irq_o);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    // R6
    pnd_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pnd_bits[i]) |-> $past(pnd_set[i]));
    // R7
    pnd_fall_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pnd_bits[i]) |-> $past(pnd_clr[i]) && !$past(pnd_set[i]));
  end
endmodule

bind acr_regfile acr_regfile_chk #(.NSRC(acr_pkg::NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .core_start_o(core_start_o),
  .go_flag(go_flag), .gie_wr(gie_wr), .pnd_bits(pnd_bits),
  .pnd_set(pnd_set), .pnd_clr(pnd_clr),
  .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
  .rvalid(s_rvalid), .rready(s_rready), .rresp(s_rresp), .rdata(s_rdata)
);

// File: tb/acr_regfile_tb.sv
module acr_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic        core_start, core_done = 1'b0, core_ready = 1'b0;
  logic [63:0] desc;
  logic        irq;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  // bench model
  bit          m_go, m_auto, m_busy, m_done, m_gie;
  bit [1:0]    m_ien, m_pnd;
  bit [31:0]   m_dsc [2];
  bit          exp_pulse;

  always #5 clk = ~clk;

  acr_regfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(1'b1),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(1'b1),
    .core_start_o(core_start), .core_done_i(core_done), .core_ready_i(core_ready),
    .desc_ptr_o(desc), .irq_o(irq)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit [31:0] put_bytes(bit [31:0] o, bit [31:0] n, bit [3:0] s);
    bit [31:0] m;
    m = {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
    return (o & ~m) | (n & m);
  endfunction

  function automatic bit [31:0] model_read(int idx);
    case (idx)
      0: return {24'h0, m_auto, 3'b000, ~m_go, ~m_busy, m_done, m_go};
      1: return {31'h0, m_gie};
      2: return {30'h0, m_ien};
      3: return {30'h0, m_pnd};
      4: return m_dsc[0];
      5: return m_dsc[1];
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_step(bit wr, int idx, bit [31:0] d, bit [3:0] s,
                            bit rdc, bit ed, bit er);
    bit sw, lch;
    bit [1:0] clr;
    sw  = wr && idx == 0 && s[0] && d[0];
    lch = sw || (er && m_go && m_auto);
    clr = (wr && idx == 3 && s[0]) ? d[1:0] : 2'b00;
    m_pnd = (m_pnd & ~clr) | ({er, ed} & m_ien);
    if (sw) m_go = 1;
    else if (er && !m_auto) m_go = 0;
    if (lch) m_busy = 1;
    else if (ed) m_busy = 0;
    if (ed) m_done = 1;
    else if (rdc) m_done = 0;
    if (wr && s[0]) begin
      if (idx == 0) m_auto = d[7];
      if (idx == 1) m_gie = d[0];
      if (idx == 2) m_ien = d[1:0];
    end
    if (wr && idx == 4) m_dsc[0] = put_bytes(m_dsc[0], d, s);
    if (wr && idx == 5) m_dsc[1] = put_bytes(m_dsc[1], d, s);
    exp_pulse = lch;
  endtask

  task automatic post_checks();
    check("R3/R4 start pulse", core_start, exp_pulse);
    check("R8 irq", irq, m_gie && (m_pnd != 0));
    check("R9 desc_ptr_o", desc, {m_dsc[1], m_dsc[0]});
  endtask

  task automatic axi_write(int idx, bit [31:0] d, bit [3:0] s, bit ed, bit er);
    @(negedge clk);
    awaddr = {idx[5:0], 2'(idx & 3)};
    wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
    core_done = ed; core_ready = er;
    @(negedge clk);
    awvalid = 0; wvalid = 0; core_done = 0; core_ready = 0;
    model_step(1, idx, d, s, 0, ed, er);
    check("R1 bvalid", bvalid, 1'b1);
    check("R1 bresp", bresp, 2'b00);
    post_checks();
  endtask

  task automatic axi_read(int idx, string req);
    bit [31:0] e;
    @(negedge clk);
    araddr = {idx[5:0], 2'b11};
    arvalid = 1;
    e = model_read(idx);
    @(negedge clk);
    arvalid = 0;
    model_step(0, idx, 0, 0, idx == 0, 0, 0);
    check("R1 rvalid", rvalid, 1'b1);
    check("R1 rresp", rresp, 2'b00);
    check(req, rdata, e);
    post_checks();
  endtask

  task automatic pulse_ev(bit ed, bit er);
    @(negedge clk);
    core_done = ed; core_ready = er;
    @(negedge clk);
    core_done = 0; core_ready = 0;
    model_step(0, 0, 0, 0, 0, ed, er);
    post_checks();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    m_go = 0; m_auto = 0; m_busy = 0; m_done = 0; m_gie = 0;
    m_ien = 0; m_pnd = 0; m_dsc[0] = 0; m_dsc[1] = 0; exp_pulse = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    check("R2 irq", irq, 1'b0);
    check("R2 start", core_start, 1'b0);
    axi_read(0, "R2 ctl reset 0x0C");
    check("R2 ctl value", model_read(0), 32'hC);
    for (int i = 1; i < 6; i++) axi_read(i, "R2 reg reset");

    // R3 software launch, R4 ready clears without auto
    axi_write(0, 32'h1, 4'h1, 0, 0);
    pulse_ev(0, 0);
    axi_read(0, "R5 ctl busy");
    pulse_ev(1, 0);
    axi_read(0, "R5 done set");
    axi_read(0, "R5 done cleared by read");
    pulse_ev(0, 1);
    axi_read(0, "R4 go cleared");

    // R4 auto restart
    axi_write(0, 32'h81, 4'h1, 0, 0);
    pulse_ev(0, 1);
    pulse_ev(0, 1);
    pulse_ev(1, 1);
    axi_read(0, "R4 auto keeps go");
    axi_write(0, 32'h0, 4'h1, 0, 0);
    pulse_ev(0, 1);
    axi_read(0, "R4 go drops after auto off");

    // R6/R7/R8 interrupt path
    axi_write(2, 32'h3, 4'hF, 0, 0);
    pulse_ev(1, 1);
    axi_read(3, "R6 pending both");
    axi_write(1, 32'hFFFF_FFFF, 4'hF, 0, 0);
    axi_read(1, "R10 gie reserved bits");
    axi_write(3, 32'h1, 4'h1, 0, 0);
    axi_read(3, "R7 clear done only");
    axi_write(3, 32'h0, 4'hF, 0, 0);
    axi_read(3, "R7 write 0 no change");
    axi_write(3, 32'h2, 4'h1, 0, 1);
    axi_read(3, "R7 set wins over clear");
    axi_write(3, 32'h3, 4'h1, 0, 0);
    axi_write(2, 32'h0, 4'h1, 0, 0);
    pulse_ev(1, 1);
    axi_read(3, "R6 disabled source not latched");
    axi_write(2, 32'h1, 4'h1, 0, 0);
    pulse_ev(0, 1);
    axi_read(3, "R6 ready masked");
    pulse_ev(1, 0);
    axi_write(1, 32'h0, 4'h1, 0, 0);
    check("R8 gie off gates irq", irq, 1'b0);

    // R9/R10 descriptor and undefined slots
    axi_write(4, 32'hDEAD_BEEF, 4'hF, 0, 0);
    axi_write(5, 32'h0123_4567, 4'h5, 0, 0);
    axi_read(5, "R9 high word strobed");
    axi_write(17, 32'hFFFF_FFFF, 4'hF, 0, 0);
    axi_read(17, "R10 undefined reads 0");
    for (int i = 0; i < 6; i++) axi_read(i, "R10 undefined write no effect");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op, idx;
      op = $urandom % 4;
      idx = ($urandom % 5 == 0) ? 6 + ($urandom % 58) : ($urandom % 6);
      case (op)
        0: axi_write(idx, $urandom, 4'($urandom), 0, 0);
        1: axi_read(idx, "R9/R10 random read");
        2: pulse_ev(1'($urandom), 1'($urandom));
        default: axi_write(($urandom % 2) ? 3 : 4 + ($urandom % 2), $urandom,
                           4'($urandom), 1'($urandom), 1'($urandom));
      endcase
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule